// File: doc/BRIEF.md
# Band-Approximated Unsigned Multiplier

This block multiplies two unsigned operands of equal width and returns the full double-width product. Every operand bit pair is ANDed into a partial product. The partial products are then compressed column by column into two rows, in the manner of a Dadda reduction, and a ripple-carry adder adds the two rows. The product is either driven combinationally or held in a single output register.

Accuracy is traded for hardware only inside a band of middle-significance columns. Inside that band, every group of eight bits is handled by an approximate eight-input compressor. Low and high columns always use exact full adders.

The compressor pairs its eight inputs. Its sum output is the OR of the four pair XORs. Each of its two carries is the OR of the pair ANDs in one half of the group. Its result can therefore never be larger than the true count of its inputs. It follows that the product can fall short of the exact value but can never exceed it.

The band defaults to columns 7 to 10 for 8-bit operands. For other widths it defaults to columns N/2 to 3N/2-1. A parameter turns the approximation off and makes the block an exact multiplier.

Top module: `apx_mult`

## Requirements
- R1: With APPROX=0, p_o equals a_i*b_i for every operand pair.
- R2: With APPROX=1, p_o never exceeds a_i*b_i. For 8-bit operands the shortfall never exceeds 15360, which is eight times the summed weights of columns 7 to 10.
- R3: Product bits below BAND_LO are always exact: p_o[BAND_LO-1:0] equals the low BAND_LO bits of a_i*b_i.
- R4: For 8-bit operands, if no partial product a_i[i]&b_i[j] with 7 <= i+j <= 10 is 1, the product is exact.
- R5: With REG_OUT=1, driving rst_ni low clears p_o to 0 without waiting for a clock edge. After reset, p_o shows the product of the operands present at the preceding rising edge of clk_i.
- R6: With REG_OUT=0, p_o follows the operands combinationally, with no clock edge in between.
- R7: Over all 65536 8-bit operand pairs, the mean absolute error distance is greater than 0 and less than 4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| p_o | output | 2*N | Product, exact or approximate according to APPROX |

## Verification
The bench builds the block four times. Two 8-bit copies, one approximate and registered and one exact and combinational, share every one of the 65536 operand pairs. That exhaustive sweep brings in reach the exact-mode equality, the one-sided error and its bound, the exact low columns, the operand pairs that avoid the band, and the mean error distance. Two 16-bit registered copies, one approximate and one exact, cover the wider default band (columns 8 to 23) with corner operands and a pseudo-random stream. The 16-bit exact copy also gives a known value for the first product after reset.

// File: rtl/apx_mult_pkg.sv
package apx_mult_pkg;

  // {carry, sum}
  function automatic logic [1:0] fa3(input logic x, input logic y, input logic z);
    return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
  endfunction

  // {carry_hi, carry_lo, sum}; value never exceeds popcount of grp
  function automatic logic [2:0] cmp82_apx(input logic [7:0] grp);
    logic [3:0] pr_x;
    logic [3:0] pr_a;
    for (int k = 0; k < 4; k++) begin
      pr_x[k] = grp[2*k] ^ grp[2*k+1];
      pr_a[k] = grp[2*k] & grp[2*k+1];
    end
    return {pr_a[3] | pr_a[2], pr_a[1] | pr_a[0], |pr_x};
  endfunction

endpackage

// File: rtl/apx_mult_pp.sv
module apx_mult_pp #(
  parameter int N = 8
) (
  input  logic [N-1:0]         a_i,
  input  logic [N-1:0]         b_i,
  output logic [N-1:0][N-1:0]  pp_o
);

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign pp_o[i][j] = a_i[i] & b_i[j];
    end
  end

endmodule

// File: rtl/apx_mult_reduce.sv
module apx_mult_reduce
  import apx_mult_pkg::*;
#(
  parameter int N       = 8,
  parameter bit APPROX  = 1'b1,
  parameter int BAND_LO = 7,
  parameter int BAND_HI = 10
) (
  input  logic [N-1:0][N-1:0] pp_i,
  output logic [2*N-1:0]      row0_o,
  output logic [2*N-1:0]      row1_o
);

  localparam int W = 2 * N;
  localparam int H = 2 * N + 4;  // bound on bits held by one column

  // Columns are processed low to high; carries of column c join column c+1.
  always_comb begin
    logic       col [H];
    logic       cry [H];
    int         cnt;
    int         ccnt;
    logic [7:0] grp;
    logic [2:0] cmp;
    logic [1:0] fa;
    for (int k = 0; k < H; k++) begin
      col[k] = 1'b0;
      cry[k] = 1'b0;
    end
    cnt    = 0;
    ccnt   = 0;
    grp    = '0;
    cmp    = '0;
    fa     = '0;
    row0_o = '0;
    row1_o = '0;
    for (int c = 0; c < W; c++) begin
      cnt = 0;
      for (int k = 0; k < H; k++) begin
        if (k < ccnt) begin
          col[cnt] = cry[k];
          cnt++;
        end
      end
      ccnt = 0;
      for (int i = 0; i < N; i++) begin
        if ((c - i >= 0) && (c - i < N)) begin
          col[cnt] = pp_i[i][c-i];
          cnt++;
        end
      end
      if (APPROX && (c >= BAND_LO) && (c <= BAND_HI)) begin
        for (int it = 0; it < H; it++) begin
          if (cnt >= 8) begin
            for (int q = 0; q < 8; q++) grp[q] = col[cnt-8+q];
            cnt -= 8;
            cmp = cmp82_apx(grp);
            col[cnt] = cmp[0];
            cnt++;
            cry[ccnt]   = cmp[1];
            cry[ccnt+1] = cmp[2];
            ccnt += 2;
          end
        end
      end
      for (int it = 0; it < H; it++) begin
        if (cnt > 2) begin
          fa = fa3(col[cnt-1], col[cnt-2], col[cnt-3]);
          cnt -= 3;
          col[cnt] = fa[0];
          cnt++;
          cry[ccnt] = fa[1];
          ccnt++;
        end
      end
      row0_o[c] = (cnt > 0) ? col[0] : 1'b0;
      row1_o[c] = (cnt > 1) ? col[1] : 1'b0;
    end
  end

endmodule

// File: rtl/apx_mult_rca.sv
module apx_mult_rca
  import apx_mult_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);

  logic [W-1:0] cin;
  assign cin[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic [1:0] r;
    assign r      = fa3(x_i[k], y_i[k], cin[k]);
    assign s_o[k] = r[0];
    if (k < W - 1) begin : g_chain
      assign cin[k+1] = r[1];
    end
  end

endmodule

// File: rtl/apx_mult.sv
module apx_mult #(
  parameter int N       = 8,
  parameter bit APPROX  = 1'b1,
  parameter bit REG_OUT = 1'b1,
  parameter int BAND_LO = (N == 8) ? 7 : N / 2,
  parameter int BAND_HI = (N == 8) ? 10 : (3 * N) / 2 - 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o
);

  localparam int W = 2 * N;

  logic [N-1:0][N-1:0] pp;
  logic [W-1:0]        row0;
  logic [W-1:0]        row1;
  logic [W-1:0]        sum;

  apx_mult_pp #(.N(N)) u_pp (
    .a_i  (a_i),
    .b_i  (b_i),
    .pp_o (pp)
  );

  apx_mult_reduce #(
    .N       (N),
    .APPROX  (APPROX),
    .BAND_LO (BAND_LO),
    .BAND_HI (BAND_HI)
  ) u_reduce (
    .pp_i   (pp),
    .row0_o (row0),
    .row1_o (row1)
  );

  apx_mult_rca #(.W(W)) u_rca (
    .x_i (row0),
    .y_i (row1),
    .s_o (sum)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_q <= '0;
      else         p_q <= sum;
    end
    assign p_o = p_q;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk_i ^ rst_ni;
    assign p_o = sum;
  end

endmodule

// File: rtl/apx_mult_chk.sv
module apx_mult_chk #(
  parameter int N       = 8,
  parameter bit APPROX  = 1'b1,
  parameter bit REG_OUT = 1'b1,
  parameter int BAND_LO = 7,
  parameter int BAND_HI = 10
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic [2*N-1:0] p_o
);

  localparam int W = 2 * N;

  logic [W-1:0] prod_now;
  assign prod_now = W'(a_i) * W'(b_i);

  if (REG_OUT) begin : g_seq
    always @(negedge clk_i) begin
      if (!rst_ni) begin
        AST_RESET_CLEAR: assert (p_o == '0) else $error("p_o not cleared in reset"); // R5
      end
    end
    AST_NO_OVERSHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (p_o <= $past(prod_now))); // R2
    AST_LOW_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (p_o[BAND_LO-1:0] == $past(prod_now[BAND_LO-1:0]))); // R3
    if (!APPROX) begin : g_ex
      AST_EXACT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (p_o == $past(prod_now))); // R1
    end
  end else begin : g_cmb
    AST_NO_OVERSHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      p_o <= prod_now); // R2
    AST_LOW_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      p_o[BAND_LO-1:0] == prod_now[BAND_LO-1:0]); // R3
    if (!APPROX) begin : g_ex
      AST_EXACT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        p_o == prod_now); // R1
    end
  end

endmodule

bind apx_mult apx_mult_chk #(
  .N       (N),
  .APPROX  (APPROX),
  .REG_OUT (REG_OUT),
  .BAND_LO (BAND_LO),
  .BAND_HI (BAND_HI)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .a_i    (a_i),
  .b_i    (b_i),
  .p_o    (p_o)
);

// File: tb/apx_mult_tb.sv
`timescale 1ns/1ps
module apx_mult_tb;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [7:0]  a8, b8;
  logic [15:0] a16, b16;
  logic [15:0] p_apx, p_ex;
  logic [31:0] p_w, p_wex;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  apx_mult #(.N(8), .APPROX(1'b1), .REG_OUT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a8), .b_i(b8), .p_o(p_apx));
  apx_mult #(.N(8), .APPROX(1'b0), .REG_OUT(1'b0)) u_exact (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a8), .b_i(b8), .p_o(p_ex));
  apx_mult #(.N(16), .APPROX(1'b1), .REG_OUT(1'b1)) u_wide (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a16), .b_i(b16), .p_o(p_w));
  apx_mult #(.N(16), .APPROX(1'b0), .REG_OUT(1'b1)) u_wide_ex (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a16), .b_i(b16), .p_o(p_wex));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit band_free8(input logic [7:0] a, input logic [7:0] b);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (a[i] && b[j] && (i + j >= 7) && (i + j <= 10)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    longint exp_w;
    a8 = 8'hff; b8 = 8'hff; a16 = 16'hffff; b16 = 16'hffff;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(p_apx == 16'd0, "R5 reset 8b", p_apx, 0);
    check(p_w == 32'd0, "R5 reset 16b", p_w, 0);
    check(p_wex == 32'd0, "R5 reset 16b exact", p_wex, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    exp_w = 64'd65535 * 64'd65535;
    check(p_wex == exp_w[31:0], "R5 first product after reset", p_wex, exp_w);
    check(p_apx[6:0] == 7'd1, "R3 low bits 255*255", p_apx[6:0], 1);
  endtask

  task automatic t_comb();
    logic [7:0] av [3] = '{8'h80, 8'hff, 8'h55};
    logic [7:0] bv [3] = '{8'h80, 8'h01, 8'haa};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1 a8 = av[k]; b8 = bv[k];
      #1 check(p_ex == 16'(av[k]) * 16'(bv[k]), "R6 combinational path", p_ex,
               16'(av[k]) * 16'(bv[k]));
    end
  endtask

  task automatic t_sweep8();
    longint err_sum = 0;
    for (int v = 0; v <= 65536; v++) begin
      @(negedge clk);
      if (v > 0) begin
        longint exp_p = longint'(a8) * longint'(b8);
        check(longint'(p_ex) == exp_p, "R1 exact 8x8", p_ex, exp_p);
        check(longint'(p_apx) <= exp_p, "R2 no overshoot 8x8", p_apx, exp_p);
        check(exp_p - longint'(p_apx) <= 15360, "R2 shortfall bound", exp_p - p_apx, 15360);
        check(p_apx[6:0] == exp_p[6:0], "R3 low bits 8x8", p_apx[6:0], exp_p[6:0]);
        if (band_free8(a8, b8))
          check(longint'(p_apx) == exp_p, "R4 band-free pair exact", p_apx, exp_p);
        err_sum += exp_p - longint'(p_apx);
      end
      if (v < 65536) begin
        a8 = v[15:8];
        b8 = v[7:0];
      end
    end
    check(err_sum > 0, "R7 mean error nonzero", err_sum, 1);
    check(err_sum < 64'd4096 * 64'd65536, "R7 mean error bound", err_sum / 65536, 4096);
  endtask

  task automatic t_wide();
    logic [31:0] x = 32'h1234_5678;
    for (int v = 0; v <= 2004; v++) begin
      @(negedge clk);
      if (v > 0) begin
        longint exp_p = longint'(a16) * longint'(b16);
        check(longint'(p_wex) == exp_p, "R1 exact 16x16", p_wex, exp_p);
        check(longint'(p_w) <= exp_p, "R2 no overshoot 16x16", p_w, exp_p);
        check(p_w[7:0] == exp_p[7:0], "R3 low bits 16x16", p_w[7:0], exp_p[7:0]);
      end
      if (v < 4) begin
        a16 = (v == 0) ? 16'd0 : (v == 1) ? 16'hffff : (v == 2) ? 16'd1 : 16'haaaa;
        b16 = (v == 0) ? 16'hffff : (v == 1) ? 16'hffff : (v == 2) ? 16'hffff : 16'h5555;
      end else if (v < 2004) begin
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        a16 = x[31:16];
        b16 = x[15:0];
      end
    end
  endtask

  initial begin
    rst_ni = 1'b1;
    a8 = '0; b8 = '0; a16 = '0; b16 = '0;
    t_reset();
    t_comb();
    t_sweep8();
    t_wide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule